// File: doc/BRIEF.md
# Nibble-Bus Firmware Memory Read Target

This block is the target side of a 4-bit, frame-strobed host bus. It answers single-byte memory reads. While idle it watches the active-low frame strobe and the shared nibble lines. On a recognised start it checks the cycle-type nibble. It then shifts in a 32-bit address over eight clocks and decides whether the address falls inside its window.

When it claims a cycle, the block takes the lines during turnaround. It emits a fixed number of "not yet" sync nibbles, then a "ready" nibble, then the data byte as two nibbles. It drives a closing turnaround nibble and finally releases the lines.

The data comes from a small computed memory model with a registered read port. That port is read once per claimed cycle, during the host's turnaround clock. The shared lines are modelled as a separate output nibble plus an output enable; the pad tri-state sits outside the block.

The bus has no stall mechanism. The host cannot apply back-pressure and the target never waits on anything external. Every claimed cycle therefore has a fixed length.

Top module: `lpcr_target`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `nib_oe` is 0.
- R2: A cycle starts on a rising edge at which `frame_n` is 0 and `nib_in` is 4'b0000. That edge is clock 1 of the cycle.
- R3: The nibble sampled at clock 2 is the cycle type. The cycle proceeds only when bits 3:2 are 2'b01 and bit 1 is 0 (read). Bit 0 is ignored, so 4'b0100 and 4'b0101 are both accepted.
- R4: Clocks 3 to 10 carry address bits 31:0, most significant nibble first. The target claims the cycle only when bits 31:23 are all 1 and bit 22 is 1 (memory space). The memory index is the low `ADDR_W` bits (6 by default).
- R5: In a claimed cycle the target does not drive during clock 11. It drives 4'b1111 during clock 12.
- R6: The target drives the wait code 4'b0101 during clocks 13 and 14 (`WSYNC_CLKS` = 2). It then drives the ready code 4'b0000 during clock 15.
- R7: The target drives the data low nibble during clock 16 and the high nibble during clock 17. The byte at index a is (29*a + 7) mod 256.
- R8: The target drives 4'b1111 during clock 18 and releases the lines (`nib_oe` = 0) in clock 19. A full cycle is 19 clocks.
- R9: A cycle with a wrong start nibble, a wrong cycle type, or an address outside the window is never driven (`nib_oe` stays 0).
- R10: If `frame_n` is 0 at any edge during a cycle, the target drops `nib_oe` in the next clock. The nibble at that edge is then treated as a fresh start nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| nib_in | input | 4 | Nibble lines as seen by the target |
| nib_out | output | 4 | Nibble the target places on the lines when enabled |
| nib_oe | output | 1 | Enable for the target's drivers on the shared lines |

## Verification
The target samples what the host drives in clock k at the edge that ends clock k. The target's response to that edge appears in clock k+1. So a claim decided at the clock-10 edge first shows as an undriven clock 11, followed by drive from clock 12 through 18. An abort at clock k is seen as released lines in clock k+1.

The bench keeps a queue of per-clock expected enable/nibble pairs, filled at the clock-10 edge of each claimed cycle. At every falling edge it pops one entry and compares it with the outputs. In the same step it drives the host's nibble for that clock, so expectations and stimulus share one clock count. A new start clock flushes the queue only after that clock's own comparison. This keeps aborted cycles aligned.

// File: rtl/lpcr_pkg.sv
package lpcr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_TAR_HOST,
    ST_TAR_DRV,
    ST_WSYNC,
    ST_RSYNC,
    ST_DLO,
    ST_DHI,
    ST_TAR_END
  } lpcr_state_e;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_WAIT  = 4'b0101;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_TURN  = 4'b1111;
  localparam int         ADDR_NIBS = 8;
endpackage

// File: rtl/lpcr_addr_shift.sv
module lpcr_addr_shift #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [3:0]        nib,
  output logic              win_hit,
  output logic [ADDR_W-1:0] mem_idx
);
  logic [31:0] addr_q;
  logic [31:0] addr_nx;

  assign addr_nx = {addr_q[27:0], nib};

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (shift_en) addr_q <= addr_nx;
  end

  // window: top nine bits set, bit 22 selects memory space
  assign win_hit = (&addr_nx[31:23]) && addr_nx[22];
  assign mem_idx = addr_q[ADDR_W-1:0];
endmodule

// File: rtl/lpcr_rom.sv
module lpcr_rom #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [7:0]        rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= 8'(32'(rd_idx) * 32'd29 + 32'd7);
  end

  // R7: returned byte holds still between reads
  assert_rom_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/lpcr_nib_drive.sv
module lpcr_nib_drive
  import lpcr_pkg::*;
(
  input  lpcr_state_e st,
  input  logic [7:0]  data,
  output logic [3:0]  nib_out,
  output logic        nib_oe
);
  always_comb begin
    nib_oe  = 1'b1;
    nib_out = NIB_TURN;
    unique case (st)
      ST_TAR_DRV: nib_out = NIB_TURN;
      ST_WSYNC:   nib_out = NIB_WAIT;
      ST_RSYNC:   nib_out = NIB_READY;
      ST_DLO:     nib_out = data[3:0];
      ST_DHI:     nib_out = data[7:4];
      ST_TAR_END: nib_out = NIB_TURN;
      default:    nib_oe  = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpcr_target.sv
module lpcr_target
  import lpcr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int WSYNC_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] nib_in,
  output logic [3:0] nib_out,
  output logic       nib_oe
);
  localparam int AC_W = $clog2(ADDR_NIBS);
  localparam int WC_W = $clog2(WSYNC_CLKS + 1);

  lpcr_state_e       st, st_nx;
  logic [AC_W-1:0]   acnt;
  logic [WC_W-1:0]   wcnt;
  logic              win_hit;
  logic [ADDR_W-1:0] mem_idx;
  logic [7:0]        rd_data;

  lpcr_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .shift_en(st == ST_ADDR), .nib(nib_in),
    .win_hit(win_hit), .mem_idx(mem_idx)
  );

  lpcr_rom #(.ADDR_W(ADDR_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .rd_en(st == ST_TAR_HOST),
    .rd_idx(mem_idx), .rd_data(rd_data)
  );

  lpcr_nib_drive u_drv (
    .st(st), .data(rd_data), .nib_out(nib_out), .nib_oe(nib_oe)
  );

  always_comb begin
    st_nx = st;
    if (!frame_n) begin
      st_nx = (nib_in == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:     st_nx = ST_IDLE;
        ST_CTYPE:    st_nx = (nib_in[3:1] == 3'b010) ? ST_ADDR : ST_IDLE;
        ST_ADDR:     if (acnt == AC_W'(ADDR_NIBS - 1))
                       st_nx = win_hit ? ST_TAR_HOST : ST_IDLE;
        ST_TAR_HOST: st_nx = ST_TAR_DRV;
        ST_TAR_DRV:  st_nx = ST_WSYNC;
        ST_WSYNC:    if (wcnt == WC_W'(WSYNC_CLKS - 1)) st_nx = ST_RSYNC;
        ST_RSYNC:    st_nx = ST_DLO;
        ST_DLO:      st_nx = ST_DHI;
        ST_DHI:      st_nx = ST_TAR_END;
        ST_TAR_END:  st_nx = ST_IDLE;
        default:     st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      acnt <= '0;
      wcnt <= '0;
    end else begin
      st   <= st_nx;
      acnt <= (st == ST_ADDR)  ? acnt + 1'b1 : '0;
      wcnt <= (st == ST_WSYNC) ? wcnt + 1'b1 : '0;
    end
  end

  // R5: drive begins only after the host turnaround clock
  assert_drive_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nib_oe) |-> $past(st == ST_TAR_HOST));

  // R6: data low nibble follows a ready nibble
  assert_ready_before_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DLO) |-> ($past(st == ST_RSYNC) && $past(nib_out) == NIB_READY));

  // R8: normal release follows a turnaround nibble
  assert_release_after_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nib_oe) && $past(frame_n)) |-> $past(nib_out) == NIB_TURN);

  // R10: frame strobe low always releases the lines next clock
  assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !nib_oe);

  // R1: lines released directly after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !nib_oe);
endmodule

// File: tb/lpcr_target_tb_top.sv
`timescale 1ns/1ps
module lpcr_target_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [3:0] nib_in = 4'hF;
  logic [3:0] nib_out;
  logic       nib_oe;

  int    vectors = 0;
  int    fails = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];
  string def_tag = "R1";

  always #2.5 clk = ~clk;

  lpcr_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
    .nib_in(nib_in), .nib_out(nib_out), .nib_oe(nib_oe)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    int idx = int'(a[5:0]);
    return 8'((idx * 29 + 7) % 256);
  endfunction

  // one bus clock: compare this clock's outputs, then drive the host side
  task automatic tick(input logic fr, input logic [3:0] nb);
    logic [4:0] e;
    string t;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = 5'b0_1111;
      t = def_tag;
    end
    vectors++;
    if (nib_oe !== e[4] || (e[4] && nib_out !== e[3:0])) begin
      fails++;
      $display("FAIL %s: actual oe=%b nib=%h expected oe=%b nib=%h",
               t, nib_oe, nib_out, e[4], e[3:0]);
    end
    frame_n = fr;
    nib_in  = nb;
    @(posedge clk);
  endtask

  task automatic push(input logic oe, input logic [3:0] n, input string t);
    exp_q.push_back({oe, n});
    tag_q.push_back(t);
  endtask

  // host cycle; upto limits how many of the 19 clocks are driven
  task automatic run_cycle(input logic [3:0] st, input logic [3:0] ct,
                           input logic [31:0] a, input int upto);
    logic claim;
    logic [7:0] b;
    claim = (st == 4'h0) && (ct[3:1] == 3'b010) && (&a[31:22]);
    b = mem_byte(a);
    tick(1'b0, st);                   // R2 start clock
    exp_q.delete();
    tag_q.delete();
    if (upto >= 2) tick(1'b1, ct);    // R3 cycle type
    for (int k = 3; k <= 10 && k <= upto; k++)
      tick(1'b1, a[4*(10-k) +: 4]);   // R4 address, MSN first
    if (upto >= 10 && claim) begin
      push(1'b0, 4'hF, "R5");
      push(1'b1, 4'hF, "R5");
      push(1'b1, 4'h5, "R6");
      push(1'b1, 4'h5, "R6");
      push(1'b1, 4'h0, "R6");
      push(1'b1, b[3:0], "R7");
      push(1'b1, b[7:4], "R7");
      push(1'b1, 4'hF, "R8");
      push(1'b0, 4'hF, "R8");
    end
    for (int k = 11; k <= 19 && k <= upto; k++)
      tick(1'b1, 4'hF);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 4'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8: actual run still busy, expected completion before watchdog");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 reset state, checked during and after reset
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    def_tag = "R9";

    run_cycle(4'h0, 4'h4, 32'hFFC0_0000, 19); // R7 index 0
    idle(2);
    run_cycle(4'h0, 4'h5, 32'hFFFF_FF3F, 19); // R3 bit0 ignored, index 63
    run_cycle(4'h0, 4'h4, 32'hFFC0_0015, 19); // back to back
    idle(3);
    run_cycle(4'h0, 4'h6, 32'hFFC0_0001, 19); // R3 write type: no drive
    run_cycle(4'h0, 4'hC, 32'hFFC0_0001, 19); // R3 wrong type
    run_cycle(4'h0, 4'h4, 32'hFFBF_0002, 19); // R4 register space
    run_cycle(4'h0, 4'h4, 32'hFF7F_FFFF, 19); // R4 bit 23 clear
    run_cycle(4'h2, 4'h4, 32'hFFC0_0003, 19); // R9 bad start nibble
    run_cycle(4'h0, 4'h4, 32'hFFC0_0007, 14); // R10 abort in wait sync
    run_cycle(4'h0, 4'h4, 32'hFFC0_0009, 16); // R10 abort in data
    run_cycle(4'h0, 4'h4, 32'hFFC0_000A, 19); // restarted read completes
    run_cycle(4'h0, 4'h4, 32'hFFC0_000B, 6);  // R10 abort in address
    run_cycle(4'h3, 4'h4, 32'hFFC0_000C, 1);  // R10 abort to idle
    idle(4);
    run_cycle(4'h0, 4'h4, 32'hFFC0_002A, 19);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule